// File: doc/BRIEF.md
# SD Card SPI Initialization Sequencer

This block takes an SD memory card from power-up to the ready state over a four-wire SPI link. After a start pulse it holds the card deselected while a power-up delay elapses. It then sends the wake-up clocks and walks a fixed command sequence. Each command frame carries its own CRC7 and runs in SPI mode 0 at a slow serial clock. The serial clock comes from the system clock through a parameterized divider; the default gives 250 kHz from 200 MHz.

Each command runs in its own chip-select window. Once a response is in, the select line is released and one more byte of clocks follows. The sequencer hunts for the response byte past filler bytes. After the interface-condition command it always clocks in all five bytes of the reply. It then polls the application initialization command until the card drops its idle flag. At the end it gives a one-cycle done pulse, or a sticky error with a code. A flag tells whether the card answered the interface-condition command, which marks a version-2 card.

Top module: `sd_spi_init_seq`

## Requirements
- R1: Out of reset and while not busy, `cs_n` is 1, `mosi` is 1, `sclk` is 0, and `done` and `err` are 0.
- R2: After `start`, `cs_n` and `mosi` stay 1 and `sclk` stays low for WAIT_CYCLES system clocks. Then exactly 80 `sclk` cycles run with `cs_n` high before `cs_n` first goes low.
- R3: Commands are six bytes, sent MSB first: `01` plus the 6-bit index, then a 32-bit argument, then the CRC7 (x^7+x^3+1 over the first five bytes) and an end bit of 1. The order is index 0 (arg 0), index 59 (arg 1), index 8 (arg 0x1AA), then pairs of index 55 (arg 0) and index 41 (arg 0x40000000).
- R4: SPI mode 0. `sclk` high and low phases last HALF_DIV system clocks. `mosi` changes only while `sclk` is low, and MISO is sampled on the rising edge.
- R5: Response bytes with bit 7 set are skipped as filler. The first byte with bit 7 clear is the R1. If HUNT_LIMIT filler bytes pass with no R1, the run fails with `err_code` 1. In that case exactly 6+HUNT_LIMIT bytes are clocked in that select window.
- R6: After index 8, four bytes follow the R1 and are always clocked, whatever the R1 value. If the R1 has bit 2 clear, the run fails with `err_code` 3 unless the last byte is 0xAA and the low nibble of the byte before it is 1.
- R7: If the index-8 R1 has bit 2 set, `card_v2` ends at 0 and the sequence still continues with the polling pair. If the reply is valid, `card_v2` is 1.
- R8: `cs_n` rises after every response. Exactly 8 `sclk` cycles with `cs_n` high come before the next `cs_n` low, including between index 55 and index 41.
- R9: While the index-41 R1 has bit 0 (idle) set, the pair is repeated. When bit 0 is clear, `done` pulses for exactly one cycle after the trailing byte.
- R10: An R1 with bit 2 (illegal command) set on any command other than index 8 fails the run with `err_code` 2. For example, 0x05 after index 41 fails.
- R11: After RETRY_LIMIT index-41 responses with idle set, the run fails with `err_code` 4.
- R12: `busy` is 1 from the cycle after `start` until the cycle where `done` pulses or `err` rises. `done` and `err` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin initialization (accepted when not busy) |
| miso | input | 1 | Serial data from card |
| sclk | output | 1 | Serial clock to card |
| mosi | output | 1 | Serial data to card |
| cs_n | output | 1 | Active-low card select |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | Sticky failure flag, cleared by start |
| err_code | output | 3 | 0 none, 1 timeout, 2 illegal, 3 bad R7, 4 retries out |
| card_v2 | output | 1 | Card answered index 8 without illegal flag |

## Verification
A card model reacts on the serial-clock edges. It takes each MOSI bit at the rising edge and presents a MISO bit after each falling edge, so a response byte is due on the byte just after the sixth command byte plus the chosen filler count. Each frame is compared against a scoreboard entry the moment its 48th bit is clocked. The window length and the count of deselected clocks are checked the instant `cs_n` changes. `done` and `err` appear one system clock after the final falling edge of the trailing byte. The bench polls them on every falling system-clock edge, so the one-cycle pulse cannot be missed.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_WAKE, ST_LAUNCH, ST_CMD, ST_HUNT, ST_R7, ST_TAIL
  } sdi_state_e;

  typedef enum logic [2:0] {
    STEP_GO_IDLE, STEP_CRC_ON, STEP_IF_COND, STEP_APP, STEP_OP_COND
  } sdi_step_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_ILLEGAL = 3'd2,
    ERR_R7      = 3'd3,
    ERR_RETRY   = 3'd4
  } sdi_err_e;

endpackage

// File: rtl/sdi_clkdiv.sv
module sdi_clkdiv #(
  parameter int HALF_DIV = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdi_crc7.sv
module sdi_crc7 #(
  parameter int MSG_W = 40
) (
  input  logic [MSG_W-1:0] msg,
  output logic [6:0]       crc
);
  always_comb begin
    logic [6:0] acc;
    logic       fb;
    acc = '0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb  = msg[i] ^ acc[6];
      acc = {acc[5:0], 1'b0};
      if (fb) acc = acc ^ 7'h09;
    end
    crc = acc;
  end
endmodule

// File: rtl/sdi_spi_byte.sv
module sdi_spi_byte #(
  parameter int HALF_DIV = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx
);
  logic       run_q, sclk_q, mosi_q, done_q;
  logic [7:0] sh_q, rx_q;
  logic [2:0] ecnt_q;
  logic       tick;

  sdi_clkdiv #(.HALF_DIV(HALF_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .en(run_q), .tick(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b1;
      done_q <= 1'b0;
      sh_q   <= 8'hFF;
      rx_q   <= 8'hFF;
      ecnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        run_q  <= 1'b1;
        sh_q   <= tx;
        mosi_q <= tx[7];
        ecnt_q <= '0;
      end else if (run_q && tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (ecnt_q == 3'd7) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
            mosi_q <= 1'b1;
          end else begin
            ecnt_q <= ecnt_q + 1'b1;
            sh_q   <= {sh_q[6:0], 1'b1};
            mosi_q <= sh_q[6];
          end
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign byte_done = done_q;
  assign rx        = rx_q;
endmodule

// File: rtl/sd_spi_init_seq.sv
module sd_spi_init_seq
  import sdi_pkg::*;
#(
  parameter int HALF_DIV    = 400,
  parameter int WAIT_CYCLES = 200000,
  parameter int HUNT_LIMIT  = 256,
  parameter int RETRY_LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [2:0] err_code,
  output logic       card_v2
);
  localparam int WAKE_BYTES = 10;
  localparam int CNT_MAX    = (WAIT_CYCLES > HUNT_LIMIT) ? WAIT_CYCLES : HUNT_LIMIT;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int RTY_W      = $clog2(RETRY_LIMIT + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  sdi_state_e       state_q, state_n;
  sdi_step_e        step_q, step_n;
  sdi_err_e         fail_q, fail_n, code_q, code_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [RTY_W-1:0] rty_q, rty_n;
  logic [2:0]       bidx_q, bidx_n;
  logic [11:0]      r7_q, r7_n;
  logic             idle_q, idle_n, ill_q, ill_n;
  logic             err_q, err_n, done_q, done_n, v2_q, v2_n, cs_q, cs_n_n;

  logic             go, byte_done;
  logic [7:0]       tx, rx, frame_byte;
  logic [5:0]       cmd_idx;
  logic [31:0]      cmd_arg;
  logic [6:0]       crc;
  logic [47:0]      frame;

  always_comb begin
    unique case (step_q)
      STEP_GO_IDLE: begin cmd_idx = 6'd0;  cmd_arg = 32'h0000_0000; end
      STEP_CRC_ON:  begin cmd_idx = 6'd59; cmd_arg = 32'h0000_0001; end
      STEP_IF_COND: begin cmd_idx = 6'd8;  cmd_arg = 32'h0000_01AA; end
      STEP_APP:     begin cmd_idx = 6'd55; cmd_arg = 32'h0000_0000; end
      default:      begin cmd_idx = 6'd41; cmd_arg = 32'h4000_0000; end
    endcase
  end

  sdi_crc7 #(.MSG_W(40)) crc_i (.msg({2'b01, cmd_idx, cmd_arg}), .crc(crc));
  assign frame = {2'b01, cmd_idx, cmd_arg, crc, 1'b1};

  always_comb begin
    unique case (bidx_q)
      3'd0:    frame_byte = frame[47:40];
      3'd1:    frame_byte = frame[39:32];
      3'd2:    frame_byte = frame[31:24];
      3'd3:    frame_byte = frame[23:16];
      3'd4:    frame_byte = frame[15:8];
      3'd5:    frame_byte = frame[7:0];
      default: frame_byte = 8'hFF;
    endcase
  end

  sdi_spi_byte #(.HALF_DIV(HALF_DIV)) spi_i (
    .clk(clk), .rst_n(rst_i_n), .go(go), .tx(tx), .miso(miso),
    .sclk(sclk), .mosi(mosi), .byte_done(byte_done), .rx(rx)
  );

  always_comb begin
    state_n = state_q; step_n = step_q; fail_n = fail_q; code_n = code_q;
    cnt_n = cnt_q; rty_n = rty_q; bidx_n = bidx_q; r7_n = r7_q;
    idle_n = idle_q; ill_n = ill_q; err_n = err_q; v2_n = v2_q;
    cs_n_n = cs_q; done_n = 1'b0; go = 1'b0; tx = 8'hFF;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_WAIT; cnt_n = '0; err_n = 1'b0; code_n = ERR_NONE;
        fail_n = ERR_NONE; rty_n = '0; step_n = STEP_GO_IDLE; v2_n = 1'b0;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_W'(WAIT_CYCLES - 1)) begin
          state_n = ST_WAKE; cnt_n = '0; go = 1'b1;
        end else cnt_n = cnt_q + 1'b1;
      end
      ST_WAKE: if (byte_done) begin
        if (cnt_q == CNT_W'(WAKE_BYTES - 1)) begin
          state_n = ST_LAUNCH; cnt_n = '0; bidx_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1; go = 1'b1;
        end
      end
      ST_LAUNCH: begin
        cs_n_n = 1'b0; go = 1'b1; tx = frame_byte;
        bidx_n = bidx_q + 1'b1; state_n = ST_CMD;
      end
      ST_CMD: if (byte_done) begin
        go = 1'b1;
        if (bidx_q == 3'd6) begin
          state_n = ST_HUNT; cnt_n = '0;
        end else begin
          tx = frame_byte; bidx_n = bidx_q + 1'b1;
        end
      end
      ST_HUNT: if (byte_done) begin
        go = 1'b1;
        if (!rx[7]) begin
          idle_n = rx[0]; ill_n = rx[2]; cnt_n = '0;
          if (step_q == STEP_IF_COND) state_n = ST_R7;
          else begin state_n = ST_TAIL; cs_n_n = 1'b1; end
        end else if (cnt_q == CNT_W'(HUNT_LIMIT - 1)) begin
          fail_n = ERR_TIMEOUT; state_n = ST_TAIL; cs_n_n = 1'b1;
        end else cnt_n = cnt_q + 1'b1;
      end
      ST_R7: if (byte_done) begin
        go = 1'b1; r7_n = {r7_q[3:0], rx};
        if (cnt_q == CNT_W'(3)) begin state_n = ST_TAIL; cs_n_n = 1'b1; end
        else cnt_n = cnt_q + 1'b1;
      end
      ST_TAIL: if (byte_done) begin
        bidx_n = '0; state_n = ST_LAUNCH;
        if (fail_q != ERR_NONE) begin
          state_n = ST_IDLE; err_n = 1'b1; code_n = fail_q;
        end else if (ill_q && step_q != STEP_IF_COND) begin
          state_n = ST_IDLE; err_n = 1'b1; code_n = ERR_ILLEGAL;
        end else begin
          unique case (step_q)
            STEP_GO_IDLE: step_n = STEP_CRC_ON;
            STEP_CRC_ON:  step_n = STEP_IF_COND;
            STEP_IF_COND: begin
              step_n = STEP_APP; v2_n = !ill_q;
              if (!ill_q && r7_q != 12'h1AA) begin
                state_n = ST_IDLE; err_n = 1'b1; code_n = ERR_R7;
              end
            end
            STEP_APP:     step_n = STEP_OP_COND;
            default: begin
              if (!idle_q) begin
                state_n = ST_IDLE; done_n = 1'b1;
              end else if (rty_q == RTY_W'(RETRY_LIMIT - 1)) begin
                state_n = ST_IDLE; err_n = 1'b1; code_n = ERR_RETRY;
              end else begin
                rty_n = rty_q + 1'b1; step_n = STEP_APP;
              end
            end
          endcase
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE; step_q <= STEP_GO_IDLE; fail_q <= ERR_NONE;
      code_q <= ERR_NONE; cnt_q <= '0; rty_q <= '0; bidx_q <= '0;
      r7_q <= '0; idle_q <= 1'b0; ill_q <= 1'b0; err_q <= 1'b0;
      done_q <= 1'b0; v2_q <= 1'b0; cs_q <= 1'b1;
    end else begin
      state_q <= state_n; step_q <= step_n; fail_q <= fail_n;
      code_q <= code_n; cnt_q <= cnt_n; rty_q <= rty_n; bidx_q <= bidx_n;
      r7_q <= r7_n; idle_q <= idle_n; ill_q <= ill_n; err_q <= err_n;
      done_q <= done_n; v2_q <= v2_n; cs_q <= cs_n_n;
    end
  end

  assign cs_n     = cs_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;
  assign card_v2  = v2_q;
endmodule

// File: rtl/sd_spi_init_seq_chk.sv
module sd_spi_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic err
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && mosi));

  a_r4_mosi_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);

  a_r8_select_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sclk);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r12_done_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind sd_spi_init_seq sd_spi_init_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .done(done), .err(err)
);

// File: tb/sd_spi_init_seq_tb_top.sv
`timescale 1ns/1ps
module sd_spi_init_seq_tb_top;
  localparam int HALF = 4;
  localparam int WAITC = 40;
  localparam int HUNT = 8;
  localparam int RTY = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic miso, sclk, mosi, cs_n, busy, done, err, card_v2;
  logic [2:0] err_code;

  always #2.5 clk = ~clk;

  sd_spi_init_seq #(.HALF_DIV(HALF), .WAIT_CYCLES(WAITC), .HUNT_LIMIT(HUNT),
                    .RETRY_LIMIT(RTY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .card_v2(card_v2)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string req, longint got, longint exp, string what);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc_byte(logic [39:0] m);
    logic [46:0] v;
    v = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'b1000_1001;
    return {v[6:0], 1'b1};
  endfunction

  // scoreboard of expected command frames
  logic [47:0] exp_q[$];
  task automatic push_cmd(int idx, logic [31:0] arg);
    logic [39:0] m;
    m = {2'b01, 6'(idx), arg};
    exp_q.push_back({m, ref_crc_byte(m)});
  endtask
  task automatic push_init();
    push_cmd(0, 32'h0); push_cmd(59, 32'h1); push_cmd(8, 32'h1AA);
  endtask
  task automatic push_pair();
    push_cmd(55, 32'h0); push_cmd(41, 32'h4000_0000);
  endtask

  // card model and monitor
  int fill, ready_after, mute_idx, acmd_cnt, rbits, sess_bytes, hi_clk, last_idx;
  int first_rise, rise_cyc;
  logic [7:0] r1_8, echo, rxb, tx_sh = 8'hFF;
  logic [7:0] q[$];
  logic [7:0] fr[$];
  bit acmd_bad, have_cmd, first_sess, armed = 0, half_chk = 0;

  assign miso = tx_sh[7];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic take_cmd();
    logic [47:0] f, e;
    f = {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]};
    last_idx = int'(fr[0][5:0]);
    if (exp_q.size() == 0) chk("R3", f, 0, "unexpected command frame");
    else begin
      e = exp_q.pop_front();
      chk("R3", f, e, "command frame");
    end
    repeat (fill) q.push_back(8'hFF);
    if (last_idx == mute_idx) return;
    case (last_idx)
      8: begin
        q.push_back(r1_8); q.push_back(8'h00); q.push_back(8'h00);
        q.push_back(8'h01); q.push_back(echo);
      end
      41: begin
        acmd_cnt++;
        if (acmd_bad) q.push_back(8'h05);
        else if (acmd_cnt > ready_after) q.push_back(8'h00);
        else q.push_back(8'h01);
      end
      default: q.push_back(8'h01);
    endcase
  endtask

  always @(posedge sclk) if (armed) begin
    if (first_rise < 0) first_rise = cyc;
    rise_cyc = cyc;
    if (cs_n === 1'b0) begin
      rxb = {rxb[6:0], mosi};
      rbits++;
      if (rbits == 8) begin
        rbits = 0;
        sess_bytes++;
        if (!have_cmd) begin
          fr.push_back(rxb);
          if (fr.size() == 6) begin have_cmd = 1; take_cmd(); end
        end
      end
    end else hi_clk++;
  end

  always @(negedge sclk) if (armed) begin
    if (half_chk) begin half_chk = 0; chk("R4", cyc - rise_cyc, HALF, "sclk high phase"); end
    if (cs_n === 1'b0) begin
      if (rbits == 0) tx_sh = (q.size() > 0) ? q.pop_front() : 8'hFF;
      else tx_sh = {tx_sh[6:0], 1'b1};
    end
  end

  always @(negedge cs_n) if (armed) begin
    if (first_sess) chk("R2", hi_clk, 80, "wake clocks before first select");
    else chk("R8", hi_clk, 8, "deselected clocks between commands");
    first_sess = 0; hi_clk = 0; rbits = 0; sess_bytes = 0;
    fr.delete(); have_cmd = 0; tx_sh = 8'hFF;
  end

  always @(posedge cs_n) if (armed && have_cmd) begin
    if (last_idx == 8) chk("R6", sess_bytes, 6 + fill + 5, "bytes in index 8 window");
    else if (last_idx == mute_idx) chk("R5", sess_bytes, 6 + HUNT, "bytes before timeout");
    q.delete(); have_cmd = 0;
  end

  task automatic run(int f, logic [7:0] r8, logic [7:0] ec, int ra, int mute, bit bad);
    int n, t0;
    fill = f; r1_8 = r8; echo = ec; ready_after = ra; mute_idx = mute;
    acmd_bad = bad; acmd_cnt = 0; hi_clk = 0; first_sess = 1; first_rise = -1;
    last_idx = -1; armed = 1;
    @(negedge clk); start = 1'b1; t0 = cyc;
    @(negedge clk); start = 1'b0;
    chk("R12", busy, 1, "busy after start");
    n = 0;
    while (!(done || err) && n < 30000) begin
      @(negedge clk); n++;
      if (n == WAITC / 2) begin
        chk("R2", {cs_n, mosi, sclk}, 3'b110, "lines during power-up wait");
      end
    end
    if (n >= 30000) chk("R12", 0, 1, "run did not finish");
    chk("R2", (first_rise - t0) >= WAITC, 1, "wait before first clock");
    chk("R12", busy, 0, "busy at finish");
  endtask

  task automatic after_done();
    @(negedge clk);
    chk("R9", done, 0, "done lasts one cycle");
    repeat (4) @(negedge clk);
    chk("R3", exp_q.size(), 0, "commands left unsent");
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {cs_n, mosi, sclk, done, err, busy}, 6'b110000, "lines in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", {cs_n, mosi, sclk, done, err, busy}, 6'b110000, "lines after reset");
    chk("R3", ref_crc_byte({2'b01, 6'd0, 32'h0}), 8'h95, "reference crc index 0");
    chk("R3", ref_crc_byte({2'b01, 6'd8, 32'h1AA}), 8'h87, "reference crc index 8");

    // high-capacity card, idle for two polls
    push_init(); repeat (3) push_pair();
    half_chk = 1;
    run(1, 8'h01, 8'hAA, 2, -1, 0);
    chk("R9", done, 1, "done on ready"); chk("R9", err, 0, "no error on ready");
    chk("R7", card_v2, 1, "version-2 flag"); chk("R9", acmd_cnt, 3, "poll count");
    after_done();

    // older card rejects index 8, three fillers
    push_init(); push_pair();
    run(3, 8'h05, 8'h00, 0, -1, 0);
    chk("R7", done, 1, "done with index 8 rejected");
    chk("R7", card_v2, 0, "version-2 flag clear");
    chk("R5", err, 0, "fillers skipped");
    after_done();

    // no answer to index 55
    push_init(); push_cmd(55, 32'h0);
    run(1, 8'h01, 8'hAA, 0, 55, 0);
    chk("R5", {err, err_code}, {1'b1, 3'd1}, "timeout code");
    after_done();

    // illegal on index 41
    push_init(); push_pair();
    run(2, 8'h01, 8'hAA, 0, -1, 1);
    chk("R10", {err, err_code}, {1'b1, 3'd2}, "illegal code");
    after_done();

    // echo mismatch
    push_init();
    run(1, 8'h01, 8'hAB, 0, -1, 0);
    chk("R6", {err, err_code}, {1'b1, 3'd3}, "echo mismatch code");
    after_done();

    // never leaves idle
    push_init(); repeat (RTY) push_pair();
    run(1, 8'h01, 8'hAA, 100, -1, 0);
    chk("R11", {err, err_code}, {1'b1, 3'd4}, "retry code");
    chk("R11", acmd_cnt, RTY, "polls before giving up");
    after_done();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule